// File: doc/BRIEF.md
# Narrow-Bus Store Dispatcher

The block sits between a 32-bit processor store port and an external bus that carries only 16 data lines. A store arrives already aligned to the 32-bit lanes, with a 4-bit lane-enable mask. The block turns it into one or two halfword write transactions. It decides how many transactions to issue, which halfword each one targets, and which of the two active-low write strobes to pulse. The low-byte strobe is `bus_wr0_n` and the high-byte strobe is `bus_wr1_n`. While transactions are in flight the processor is held through a busy output. Requests made while the block is busy are not accepted.

The decisions follow the size of the access, not the exact lane mask. A full four-lane store is split into two back-to-back transactions with chip select held low. A narrower store issues a single transaction at the halfword that holds its lowest enabled lane, and any enabled lanes in the other halfword are dropped. A lone byte pulses the strobe that matches its lane parity. Wider accesses pulse both strobes.

A companion model of a pair of 16-bit slave registers is part of the project. It captures the whole data halfword on the low-byte strobe and ignores the high-byte strobe. This shows how a word store also writes the neighbouring register, and how an odd-lane byte store is lost.

Top module: `nbus_wr_dispatch`

## Requirements
- R1: A store with all four lane enables set (`cpu_be` = 4'b1111) issues two transactions. The first is at the word address with bit 1 clear and the second at that address plus 2. `bus_cs_n` stays low throughout, and `cpu_busy` is high for 6 cycles.
- R2: A store with 1 to 3 lanes enabled issues exactly one transaction, and `cpu_busy` is high for 3 cycles. The transaction's address bit 1 is 0 when lane 0 or lane 1 is enabled, otherwise 1. Enabled lanes in the other halfword produce no bus activity.
- R3: A single-lane store pulses only `bus_wr0_n` for lanes 0 and 2, and only `bus_wr1_n` for lanes 1 and 3.
- R4: A store of two or more lanes pulses both strobes in each transaction it issues.
- R5: The data of a transaction at the low halfword is `cpu_wdata[15:0]`, and at the high halfword it is `cpu_wdata[31:16]`.
- R6: Each transaction takes three cycles: setup, strobe and release. A strobe is low for exactly one cycle, and chip select is low for at least one cycle before it.
- R7: The slave register selected by address bit 1 loads all 16 data bits when `wr0_n` is low. A cycle with only `wr1_n` low leaves both registers unchanged.
- R8: A request with no lane enabled, or a request made while `cpu_busy` is high, starts no transaction.
- R9: After reset `bus_cs_n`, `bus_wr0_n` and `bus_wr1_n` are high, `cpu_busy` is low, and the slave registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req | input | 1 | Store request, taken when `cpu_busy` is low |
| cpu_addr | input | AW (24) | Byte address of the store; bits 1:0 are ignored |
| cpu_be | input | 4 | Lane enables of the shifted store |
| cpu_wdata | input | 32 | Store data, already shifted onto the lanes |
| cpu_busy | output | 1 | High while transactions are in progress |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_addr | output | AW (24) | Halfword address of the current transaction |
| bus_data | output | 16 | Write data of the current transaction |
| bus_wr0_n | output | 1 | Low-byte write strobe, active low |
| bus_wr1_n | output | 1 | High-byte write strobe, active low |

## Verification
The hardest case to reach is the split store, because the address step and the held chip select only appear between its two transactions. Each table entry therefore first writes a full-word baseline of distinct values into both slave registers, so every split store shows up as a change in the upper register. Dropped lanes and lost odd-lane bytes are seen as registers that keep that baseline. A second request is raised in the middle of a transaction to show that it is ignored rather than queued.

// File: rtl/nbus_slave.sv
module nbus_slave #(
  parameter int AW = 24,
  parameter logic [AW-1:0] BASE = 24'h001D80
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic [AW-1:0] addr,
  input  logic [15:0]   data,
  input  logic          wr0_n,
  input  logic          wr1_n,
  input  logic          rd_idx,
  output logic [15:0]   rd_data
);
  logic [1:0][15:0] mem;
  logic             hit;

  assign hit     = !cs_n && (addr[AW-1:2] == BASE[AW-1:2]);
  assign rd_data = mem[rd_idx];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) mem <= '0;
    else if (hit && !wr0_n) mem[addr[1]] <= data;

  a_r7_wr1_only_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (wr0_n && !wr1_n) |=> $stable(mem));
  a_r7_wr0_full_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !wr0_n) |=> mem[$past(addr[1])] == $past(data));
endmodule

// File: rtl/nbus_wr_dispatch.sv
module nbus_wr_dispatch #(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  logic [AW-1:0] cpu_addr,
  input  logic [3:0]    cpu_be,
  input  logic [31:0]   cpu_wdata,
  output logic          cpu_busy,
  output logic          bus_cs_n,
  output logic [AW-1:0] bus_addr,
  output logic [15:0]   bus_data,
  output logic          bus_wr0_n,
  output logic          bus_wr1_n
);
  typedef enum logic [1:0] {IDLE, SETUP, STRB, REL} ph_t;

  ph_t           ph;
  logic          more, half, en0, en1;
  logic [31:0]   dat_q;
  logic [AW-3:0] word_q;
  logic          take, single;

  assign take   = (ph == IDLE) && cpu_req && (cpu_be != 4'b0000);
  assign single = $countones(cpu_be) == 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= IDLE;
      more   <= 1'b0;
      half   <= 1'b0;
      en0    <= 1'b0;
      en1    <= 1'b0;
      dat_q  <= '0;
      word_q <= '0;
    end else begin
      case (ph)
        IDLE: if (take) begin
          ph     <= SETUP;
          more   <= &cpu_be;
          half   <= (&cpu_be) ? 1'b0 : !(cpu_be[0] || cpu_be[1]);
          en0    <= single ? (cpu_be[0] || cpu_be[2]) : 1'b1;
          en1    <= single ? (cpu_be[1] || cpu_be[3]) : 1'b1;
          dat_q  <= cpu_wdata;
          word_q <= cpu_addr[AW-1:2];
        end
        SETUP: ph <= STRB;
        STRB:  ph <= REL;
        REL: if (more) begin
          ph   <= SETUP;
          more <= 1'b0;
          half <= 1'b1;
        end else ph <= IDLE;
        default: ph <= IDLE;
      endcase
    end
  end

  assign cpu_busy  = ph != IDLE;
  assign bus_cs_n  = ph == IDLE;
  assign bus_addr  = {word_q, half, 1'b0};
  assign bus_data  = half ? dat_q[31:16] : dat_q[15:0];
  assign bus_wr0_n = !(ph == STRB && en0);
  assign bus_wr1_n = !(ph == STRB && en1);

  a_r1_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_cs_n && $past(!bus_cs_n) && bus_addr != $past(bus_addr))
      |-> bus_addr == $past(bus_addr) + AW'(2));
  a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !cpu_busy && $countones(cpu_be) == 1)
      |-> ##2 ($countones({!bus_wr0_n, !bus_wr1_n}) == 1));
  a_r4_both_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !cpu_busy && $countones(cpu_be) >= 2)
      |-> ##2 (!bus_wr0_n && !bus_wr1_n));
  a_r6_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr0_n || !bus_wr1_n) |=> (bus_wr0_n && bus_wr1_n && !bus_cs_n));
  a_r6_setup_first: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr0_n || !bus_wr1_n) |-> (!bus_cs_n && $past(!bus_cs_n)));
  a_r8_no_empty_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_busy && cpu_be == 4'b0000) |=> !cpu_busy);
endmodule

// File: tb/test_nbus_wr_dispatch.sv
module test_nbus_wr_dispatch;
  localparam int AW = 24;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [AW-1:0] BASE = 24'h001D80;

  typedef struct packed {
    logic [3:0]  be;
    logic [31:0] wd;
    logic [15:0] elo, ehi;
    logic [3:0]  cyc;
    logic [1:0]  n0, n1;
    logic        ehalf;
    logic [15:0] edat;
  } vec_t;

  localparam vec_t VEC [14] = '{
    '{4'hF, 32'hAABBCCDD, 16'hCCDD, 16'hAABB, 4'd6, 2'd2, 2'd2, 1'b0, 16'hCCDD},
    '{4'h3, 32'hAABBCCDD, 16'hCCDD, 16'h2222, 4'd3, 2'd1, 2'd1, 1'b0, 16'hCCDD},
    '{4'hC, 32'hCCDD0000, 16'h1111, 16'hCCDD, 4'd3, 2'd1, 2'd1, 1'b1, 16'hCCDD},
    '{4'h1, 32'hAABBCCDD, 16'hCCDD, 16'h2222, 4'd3, 2'd1, 2'd0, 1'b0, 16'hCCDD},
    '{4'h2, 32'hBBCCDD00, 16'h1111, 16'h2222, 4'd3, 2'd0, 2'd1, 1'b0, 16'hDD00},
    '{4'h4, 32'hCCDD0000, 16'h1111, 16'hCCDD, 4'd3, 2'd1, 2'd0, 1'b1, 16'hCCDD},
    '{4'h8, 32'hDD000000, 16'h1111, 16'h2222, 4'd3, 2'd0, 2'd1, 1'b1, 16'hDD00},
    '{4'h1, 32'h000000AA, 16'h00AA, 16'h2222, 4'd3, 2'd1, 2'd0, 1'b0, 16'h00AA},
    '{4'h3, 32'h0000AABB, 16'hAABB, 16'h2222, 4'd3, 2'd1, 2'd1, 1'b0, 16'hAABB},
    '{4'h7, 32'h00AABBCC, 16'hBBCC, 16'h2222, 4'd3, 2'd1, 2'd1, 1'b0, 16'hBBCC},
    '{4'hF, 32'hFEDCBA98, 16'hBA98, 16'hFEDC, 4'd6, 2'd2, 2'd2, 1'b0, 16'hBA98},
    '{4'hE, 32'hBBCCDD00, 16'hDD00, 16'h2222, 4'd3, 2'd1, 2'd1, 1'b0, 16'hDD00},
    '{4'hC, 32'hCCDD0000, 16'h1111, 16'hCCDD, 4'd3, 2'd1, 2'd1, 1'b1, 16'hCCDD},
    '{4'h8, 32'hDD000000, 16'h1111, 16'h2222, 4'd3, 2'd0, 2'd1, 1'b1, 16'hDD00}
  };

  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0, rd_idx = 1'b0;
  logic [AW-1:0] addr = BASE;
  logic [3:0]  be = '0;
  logic [31:0] wd = '0;
  logic busy, cs_n, wr0_n, wr1_n;
  logic [AW-1:0] baddr;
  logic [15:0] bdata, rd_data;

  int checks = 0, errors = 0, cycles = 0;
  int n0, n1, ncyc, cs_rise;
  logic got_first, prev_cs;
  logic [AW-1:0] f_addr;
  logic [15:0] f_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  nbus_wr_dispatch #(.AW(AW)) i_nbus_wr_dispatch (
    .clk(clk), .rst_n(rst_n), .cpu_req(req), .cpu_addr(addr), .cpu_be(be),
    .cpu_wdata(wd), .cpu_busy(busy), .bus_cs_n(cs_n), .bus_addr(baddr),
    .bus_data(bdata), .bus_wr0_n(wr0_n), .bus_wr1_n(wr1_n));

  nbus_slave #(.AW(AW), .BASE(BASE)) i_slave (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .addr(baddr), .data(bdata),
    .wr0_n(wr0_n), .wr1_n(wr1_n), .rd_idx(rd_idx), .rd_data(rd_data));

  always @(negedge clk) begin
    if (!wr0_n) n0++;
    if (!wr1_n) n1++;
    if (busy) ncyc++;
    if ((!wr0_n || !wr1_n) && !got_first) begin
      got_first = 1'b1; f_addr = baddr; f_data = bdata;
    end
    if (cs_n && !prev_cs) cs_rise++;
    prev_cs = cs_n;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clr();
    n0 = 0; n1 = 0; ncyc = 0; cs_rise = 0; got_first = 1'b0;
  endtask

  task automatic store(input logic [3:0] b, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; be = b; wd = d;
    @(negedge clk);
    req = 1'b0; be = '0;
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic rd(output logic [15:0] lo, output logic [15:0] hi);
    rd_idx = 1'b0; #1 lo = rd_data;
    rd_idx = 1'b1; #1 hi = rd_data;
  endtask

  initial begin
    logic [15:0] lo, hi;
    prev_cs = 1'b1;
    clr();
    repeat (3) @(negedge clk);
    chk("R9 cs_n", {31'd0, cs_n}, 32'd1);
    chk("R9 wr0_n", {31'd0, wr0_n}, 32'd1);
    chk("R9 wr1_n", {31'd0, wr1_n}, 32'd1);
    chk("R9 busy", {31'd0, busy}, 32'd0);
    rd(lo, hi);
    chk("R9 slave regs", {hi, lo}, 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < 14; i++) begin
      clr();
      store(4'hF, 32'h22221111);
      chk("R1 baseline split busy", ncyc, 6);
      chk("R1 chip select held", cs_rise, 1);
      clr();
      store(VEC[i].be, VEC[i].wd);
      rd(lo, hi);
      chk($sformatf("R7 vec%0d low reg", i), {16'd0, lo}, {16'd0, VEC[i].elo});
      chk($sformatf("R7 vec%0d high reg", i), {16'd0, hi}, {16'd0, VEC[i].ehi});
      chk($sformatf("R1 R2 vec%0d busy", i), ncyc, {28'd0, VEC[i].cyc});
      chk($sformatf("R3 R4 vec%0d wr0 pulses", i), n0, {30'd0, VEC[i].n0});
      chk($sformatf("R3 R4 vec%0d wr1 pulses", i), n1, {30'd0, VEC[i].n1});
      chk($sformatf("R2 vec%0d first addr", i), f_addr, BASE | (VEC[i].ehalf ? 24'd2 : 24'd0));
      chk($sformatf("R5 vec%0d first data", i), {16'd0, f_data}, {16'd0, VEC[i].edat});
      chk($sformatf("R6 vec%0d one cs window", i), cs_rise, 1);
    end

    clr();
    store(4'hF, 32'h22221111);
    clr();
    @(negedge clk);
    req = 1'b1; be = 4'h0; wd = 32'h99999999;
    repeat (4) @(negedge clk);
    req = 1'b0;
    rd(lo, hi);
    chk("R8 empty enables no busy", ncyc, 0);
    chk("R8 empty enables no strobe", n0 + n1, 0);
    chk("R8 empty enables regs", {hi, lo}, 32'h22221111);

    clr();
    @(negedge clk);
    req = 1'b1; be = 4'h3; wd = 32'h00005555;
    @(negedge clk);
    be = 4'hC; wd = 32'h77770000;
    @(negedge clk);
    req = 1'b0; be = '0;
    while (busy) @(negedge clk);
    @(negedge clk);
    rd(lo, hi);
    chk("R8 busy request dropped busy", ncyc, 3);
    chk("R8 busy request dropped regs", {hi, lo}, 32'h22225555);
    chk("R6 single window", cs_rise, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule